// File: doc/BRIEF.md
# Effective Address Generator for an 8-bit Processor Core

This block works out the operand address for each addressing mode of a small 8-bit processor with a 16-bit address space. The core supplies a mode code, the program counter of the first operand byte, and the two index registers, then pulses `start`. The block reads any operand or pointer bytes it needs over a one-byte read port, one byte per accepted request. It then raises `done` for one cycle. In that cycle it presents the final 16-bit address, the sign-extended branch offset, and how far the program counter must move past the operand bytes.

The read port uses a request/acknowledge handshake. The block holds `rd_req` and `rd_addr` until the memory side answers with `rd_ack` and the byte on `rd_data`, so any number of wait cycles can be added. Results stay on the outputs until the next accepted `start`. The block decodes no opcodes and does no arithmetic on data.

Top module: `ea_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `busy`, `done` and `rd_req` are low. `start` has no effect during reset.
- R2: Mode code 0 (immediate) and the unused codes 10 to 15 perform no reads. They return the given PC as the address, with a PC advance of 1.
- R3: Mode 1 (zero page) reads one byte at PC and returns it zero-extended, with an advance of 1.
- R4: Modes 2 and 3 (zero page indexed by X or by Y) return `{8'h00, (byte + index) mod 256}`, so the address never leaves page zero.
- R5: Mode 4 (absolute) reads PC first and then PC+1. It returns `{byte@PC+1, byte@PC}` (little-endian), with an advance of 2.
- R6: Modes 5 and 6 (absolute indexed by X or by Y) add the zero-extended index to the absolute address, modulo 65536.
- R7: Mode 7 (indirect) reads a little-endian pointer from PC and PC+1. It then reads the target low byte at the pointer and the high byte at pointer+1, with a full 16-bit carry (pointer 0x12FF takes its high byte from 0x1300). The advance is 2.
- R8: Mode 8 (indexed-indirect) forms p = (byte@PC + X) mod 256. It returns `{byte@(p+1), byte@p}`, where p+1 is a 16-bit increment (p = 0x00FF takes its high byte from 0x0100). The advance is 1.
- R9: Mode 9 (relative) returns `rel_off` = the operand byte sign-extended to 16 bits, and an address of PC + 1 + `rel_off` modulo 65536. The advance is 1.
- R10: While `rd_req` is high and `rd_ack` is low, `rd_req` and `rd_addr` hold steady. A byte is taken only in a cycle with `rd_ack` high.
- R11: Each accepted `start` yields exactly one `done` pulse of one cycle, and `start` is ignored while `busy` is high. With `rd_ack` high in every cycle, `done` is high N+1 cycles after `start` is sampled, where N is the number of reads the mode needs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an address computation (accepted when idle) |
| mode | input | 4 | Addressing mode code |
| pc | input | 16 | Address of the first operand byte |
| x_idx | input | 8 | X index register |
| y_idx | input | 8 | Y index register |
| rd_req | output | 1 | Read request |
| rd_addr | output | 16 | Read address |
| rd_ack | input | 1 | Read acknowledge, byte valid on rd_data |
| rd_data | input | 8 | Read data |
| busy | output | 1 | Computation in progress (through the done cycle) |
| done | output | 1 | One-cycle pulse, results valid |
| ea | output | 16 | Effective address |
| rel_off | output | 16 | Sign-extended relative offset (zero in other modes) |
| pc_adv | output | 2 | Program counter advance past the operand bytes |

## Verification
A sequencer that holds the wrong state shows up at the read port first. Reads go to the wrong address, the wrong number of reads are made, or a request drops during a stall. Any of these changes the result or the read count at the next `done`, within at most five cycles of the start. A fault in the mode-dependent address arithmetic is visible in the same `done` cycle as a wrong `ea`, `rel_off` or `pc_adv`. The corner operands are chosen so that each wrap rule gives a result distinct from its faulty alternative: index carries in page zero and at 0xFFFF, pointer carries at 0x00FF and 0x12FF, and negative branch offsets.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

    localparam int AW = 16;
    localparam int DW = 8;
    localparam int ADV_W = 2;
    localparam int MODE_W = 4;
    localparam int PAGE_W = AW - DW;

    typedef enum logic [MODE_W-1:0] {
        M_IMM    = 4'd0,
        M_ZP     = 4'd1,
        M_ZPX    = 4'd2,
        M_ZPY    = 4'd3,
        M_ABS    = 4'd4,
        M_ABSX   = 4'd5,
        M_ABSY   = 4'd6,
        M_IND    = 4'd7,
        M_IDXIND = 4'd8,
        M_REL    = 4'd9
    } amode_e;

    typedef enum logic [2:0] {
        S_IDLE, S_OP0, S_OP1, S_PT0, S_PT1, S_DONE
    } seq_st_e;

    typedef struct packed {
        logic [DW-1:0] op_lo;
        logic [DW-1:0] op_hi;
        logic [DW-1:0] tg_lo;
        logic [DW-1:0] tg_hi;
    } fetch_t;

    function automatic amode_e norm_mode(input logic [MODE_W-1:0] m);
        return (m > 4'd9) ? M_IMM : amode_e'(m);
    endfunction

    function automatic logic needs_hi(input amode_e m);
        return (m == M_ABS) || (m == M_ABSX) || (m == M_ABSY) || (m == M_IND);
    endfunction

    function automatic logic [AW-1:0] zp_wrap(input logic [DW-1:0] b, input logic [DW-1:0] i);
        logic [DW-1:0] s;
        s = b + i;
        return {{PAGE_W{1'b0}}, s};
    endfunction

    function automatic logic [AW-1:0] sext8(input logic [DW-1:0] b);
        return {{PAGE_W{b[DW-1]}}, b};
    endfunction

endpackage

// File: rtl/ea_calc.sv
module ea_calc
    import ea_gen_pkg::*;
(
    input  amode_e             mode,
    input  logic [AW-1:0]      pc,
    input  logic [DW-1:0]      xi,
    input  logic [DW-1:0]      yi,
    input  fetch_t             f,
    output logic [AW-1:0]      ptr_base,
    output logic [AW-1:0]      ea,
    output logic [AW-1:0]      rel_off,
    output logic [ADV_W-1:0]   pc_adv
);
    logic [AW-1:0] abs_a;
    logic [AW-1:0] tgt_a;

    assign abs_a = {f.op_hi, f.op_lo};
    assign tgt_a = {f.tg_hi, f.tg_lo};

    always_comb begin
        ptr_base = (mode == M_IDXIND) ? zp_wrap(f.op_lo, xi) : abs_a;
        rel_off  = (mode == M_REL) ? sext8(f.op_lo) : '0;
        pc_adv   = needs_hi(mode) ? ADV_W'(2) : ADV_W'(1);
        unique case (mode)
            M_ZP:     ea = {{PAGE_W{1'b0}}, f.op_lo};
            M_ZPX:    ea = zp_wrap(f.op_lo, xi);
            M_ZPY:    ea = zp_wrap(f.op_lo, yi);
            M_ABS:    ea = abs_a;
            M_ABSX:   ea = abs_a + {{PAGE_W{1'b0}}, xi};
            M_ABSY:   ea = abs_a + {{PAGE_W{1'b0}}, yi};
            M_IND,
            M_IDXIND: ea = tgt_a;
            M_REL:    ea = pc + AW'(1) + sext8(f.op_lo);
            default:  ea = pc;
        endcase
    end
endmodule

// File: rtl/ea_seq.sv
module ea_seq
    import ea_gen_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [MODE_W-1:0]  mode_in,
    input  logic [AW-1:0]      pc_in,
    input  logic [DW-1:0]      x_in,
    input  logic [DW-1:0]      y_in,
    input  logic               rd_ack,
    input  logic [DW-1:0]      rd_data,
    input  logic [AW-1:0]      ptr_base,
    output logic               rd_req,
    output logic [AW-1:0]      rd_addr,
    output logic               busy,
    output logic               done,
    output amode_e             mode_q,
    output logic [AW-1:0]      pc_q,
    output logic [DW-1:0]      x_q,
    output logic [DW-1:0]      y_q,
    output fetch_t             fetch
);
    seq_st_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            mode_q <= M_IMM;
            pc_q   <= '0;
            x_q    <= '0;
            y_q    <= '0;
            fetch  <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (start) begin
                    mode_q <= norm_mode(mode_in);
                    pc_q   <= pc_in;
                    x_q    <= x_in;
                    y_q    <= y_in;
                    st     <= (norm_mode(mode_in) == M_IMM) ? S_DONE : S_OP0;
                end
                S_OP0: if (rd_ack) begin
                    fetch.op_lo <= rd_data;
                    if (needs_hi(mode_q))        st <= S_OP1;
                    else if (mode_q == M_IDXIND) st <= S_PT0;
                    else                         st <= S_DONE;
                end
                S_OP1: if (rd_ack) begin
                    fetch.op_hi <= rd_data;
                    st <= (mode_q == M_IND) ? S_PT0 : S_DONE;
                end
                S_PT0: if (rd_ack) begin
                    fetch.tg_lo <= rd_data;
                    st <= S_PT1;
                end
                S_PT1: if (rd_ack) begin
                    fetch.tg_hi <= rd_data;
                    st <= S_DONE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_req = (st == S_OP0) || (st == S_OP1) || (st == S_PT0) || (st == S_PT1);
        unique case (st)
            S_OP0:   rd_addr = pc_q;
            S_OP1:   rd_addr = pc_q + AW'(1);
            S_PT0:   rd_addr = ptr_base;
            S_PT1:   rd_addr = ptr_base + AW'(1);
            default: rd_addr = '0;
        endcase
    end

    assign busy = (st != S_IDLE);
    assign done = (st == S_DONE);
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_gen_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [15:0]   pc,
    input  logic [7:0]    x_idx,
    input  logic [7:0]    y_idx,
    output logic          rd_req,
    output logic [15:0]   rd_addr,
    input  logic          rd_ack,
    input  logic [7:0]    rd_data,
    output logic          busy,
    output logic          done,
    output logic [15:0]   ea,
    output logic [15:0]   rel_off,
    output logic [1:0]    pc_adv
);
    amode_e          mode_q;
    logic [AW-1:0]   pc_q;
    logic [DW-1:0]   x_q;
    logic [DW-1:0]   y_q;
    fetch_t          fetch;
    logic [AW-1:0]   ptr_base;

    ea_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .mode_in  (mode),
        .pc_in    (pc),
        .x_in     (x_idx),
        .y_in     (y_idx),
        .rd_ack   (rd_ack),
        .rd_data  (rd_data),
        .ptr_base (ptr_base),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .busy     (busy),
        .done     (done),
        .mode_q   (mode_q),
        .pc_q     (pc_q),
        .x_q      (x_q),
        .y_q      (y_q),
        .fetch    (fetch)
    );

    ea_calc u_calc (
        .mode     (mode_q),
        .pc       (pc_q),
        .xi       (x_q),
        .yi       (y_q),
        .f        (fetch),
        .ptr_base (ptr_base),
        .ea       (ea),
        .rel_off  (rel_off),
        .pc_adv   (pc_adv)
    );
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        rd_req,
    input logic        rd_ack,
    input logic [15:0] rd_addr,
    input logic [15:0] ea,
    input logic [15:0] rel_off,
    input logic [1:0]  pc_adv,
    input logic [3:0]  mode_q
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done && !rd_req)); // R1

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!rd_req && !done)); // R1

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr))); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy)); // R11

    AST_ZP_PAGE: assert property (@(posedge clk) disable iff (rst)
        (done && (mode_q == 4'd1 || mode_q == 4'd2 || mode_q == 4'd3)) |-> (ea[15:8] == 8'h00)); // R4

    AST_REL_SEXT: assert property (@(posedge clk) disable iff (rst)
        (done && mode_q == 4'd9) |-> (rel_off[15:8] == {8{rel_off[7]}})); // R9

    AST_ADV_LEGAL: assert property (@(posedge clk) disable iff (rst)
        done |-> (pc_adv == 2'd1 || pc_adv == 2'd2)); // R2
endmodule

bind ea_gen ea_gen_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .done    (done),
    .rd_req  (rd_req),
    .rd_ack  (rd_ack),
    .rd_addr (rd_addr),
    .ea      (ea),
    .rel_off (rel_off),
    .pc_adv  (pc_adv),
    .mode_q  (mode_q)
);

// File: tb/ea_gen_bench.sv
module ea_gen_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst, start;
    logic [3:0]  mode;
    logic [15:0] pc;
    logic [7:0]  xr, yr;
    logic        rd_req, rd_ack;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data;
    logic        busy, done;
    logic [15:0] ea, rel_off;
    logic [1:0]  pc_adv;

    ea_gen u_ea_gen (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .pc(pc),
        .x_idx(xr), .y_idx(yr), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy), .done(done),
        .ea(ea), .rel_off(rel_off), .pc_adv(pc_adv)
    );

    typedef struct {
        string       req;
        logic [15:0] ea;
        logic [15:0] rel;
        logic [1:0]  adv;
        int          reads;
        int          t0;
        bit          timed;
    } exp_t;

    exp_t sbq[$];
    exp_t cur;
    int n_chk = 0, n_fail = 0, cyc = 0;
    int total_reads = 0, reads_at_done = 0, n_done = 0, n_issued = 0;
    bit stall_en = 1'b0;
    logic [7:0] ovr [logic [15:0]];

    function automatic logic [7:0] mem_rd(input logic [15:0] a);
        if (ovr.exists(a)) return ovr[a];
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rd_req && rd_ack) total_reads <= total_reads + 1;
    end

    always @(negedge clk) begin
        rd_ack = rd_req && !(stall_en && (cyc % 3 != 0));
        rd_data = rd_ack ? mem_rd(rd_addr) : 8'h00;
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            n_done++;
            if (sbq.size() == 0) begin
                check("R11 done without start", 32'd1, 32'd0);
            end else begin
                cur = sbq.pop_front();
                check({cur.req, " ea"}, {16'h0, ea}, {16'h0, cur.ea});
                check({cur.req, " rel_off"}, {16'h0, rel_off}, {16'h0, cur.rel});
                check({cur.req, " pc_adv"}, {30'h0, pc_adv}, {30'h0, cur.adv});
                check({cur.req, " read count"}, total_reads - reads_at_done, cur.reads);
                if (cur.timed)
                    check({cur.req, " R11 latency"}, cyc - cur.t0, cur.reads + 1);
            end
            reads_at_done = total_reads;
        end
    end

    task automatic issue(input string req, input logic [3:0] m, input logic [15:0] p,
                         input logic [7:0] x, input logic [7:0] y, input bit glitch);
        exp_t e;
        logic [7:0]  b0, b1;
        logic [15:0] ptr;
        b0 = mem_rd(p);
        b1 = mem_rd(p + 16'd1);
        e.req = req; e.rel = 16'h0; e.adv = 2'd1; e.reads = 0; e.ea = p;
        case (m)
            4'd1: begin e.ea = {8'h00, b0}; e.reads = 1; end
            4'd2: begin e.ea = {8'h00, b0 + x}; e.reads = 1; end
            4'd3: begin e.ea = {8'h00, b0 + y}; e.reads = 1; end
            4'd4: begin e.ea = {b1, b0}; e.adv = 2'd2; e.reads = 2; end
            4'd5: begin e.ea = {b1, b0} + {8'h00, x}; e.adv = 2'd2; e.reads = 2; end
            4'd6: begin e.ea = {b1, b0} + {8'h00, y}; e.adv = 2'd2; e.reads = 2; end
            4'd7: begin
                ptr = {b1, b0};
                e.ea = {mem_rd(ptr + 16'd1), mem_rd(ptr)}; e.adv = 2'd2; e.reads = 4;
            end
            4'd8: begin
                ptr = {8'h00, b0 + x};
                e.ea = {mem_rd(ptr + 16'd1), mem_rd(ptr)}; e.reads = 3;
            end
            4'd9: begin
                e.rel = {{8{b0[7]}}, b0};
                e.ea = p + 16'd1 + e.rel; e.reads = 1;
            end
            default: ;
        endcase
        while (busy) @(negedge clk);
        start = 1'b1; mode = m; pc = p; xr = x; yr = y;
        e.t0 = cyc; e.timed = !stall_en;
        sbq.push_back(e);
        n_issued++;
        @(negedge clk);
        start = 1'b0;
        if (glitch) begin
            start = 1'b1; mode = 4'd1; pc = 16'hBEEF; xr = 8'h55; yr = 8'h66;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b1; mode = 4'd4; pc = 16'h0; xr = 8'h0; yr = 8'h0;
        rd_ack = 1'b0; rd_data = 8'h00;
        repeat (3) @(negedge clk);
        check("R1 busy in reset", {31'h0, busy}, 32'd0);
        check("R1 rd_req in reset", {31'h0, rd_req}, 32'd0);
        start = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R1 quiet after reset", {29'h0, busy, done, rd_req}, 32'd0);

        ovr[16'h0200] = 8'h80;
        ovr[16'h0210] = 8'hF0;
        ovr[16'h0220] = 8'h05;
        ovr[16'h0300] = 8'h34; ovr[16'h0301] = 8'h12;
        ovr[16'h0310] = 8'hF0; ovr[16'h0311] = 8'hFF;
        ovr[16'h0320] = 8'hFF; ovr[16'h0321] = 8'h12;
        ovr[16'h0400] = 8'hFF; ovr[16'h0401] = 8'h12;
        ovr[16'h12FF] = 8'h78; ovr[16'h1300] = 8'h56; ovr[16'h1200] = 8'hEE;
        ovr[16'h0500] = 8'hFE; ovr[16'h00FF] = 8'hCD; ovr[16'h0100] = 8'hAB; ovr[16'h0000] = 8'h11;
        ovr[16'h0510] = 8'h80; ovr[16'h0010] = 8'h22; ovr[16'h0011] = 8'h33;
        ovr[16'h0600] = 8'h80; ovr[16'h0610] = 8'h7F; ovr[16'hFFFF] = 8'h01;

        issue("R2 immediate", 4'd0, 16'h1234, 8'h00, 8'h00, 1'b0);
        issue("R2 unused code 12", 4'd12, 16'hABCD, 8'h00, 8'h00, 1'b0);
        issue("R3 zero page", 4'd1, 16'h0200, 8'h00, 8'h00, 1'b0);
        issue("R4 zp,X wrap", 4'd2, 16'h0210, 8'h20, 8'h00, 1'b0);
        issue("R4 zp,Y", 4'd3, 16'h0220, 8'h99, 8'h03, 1'b0);
        issue("R5 absolute", 4'd4, 16'h0300, 8'h00, 8'h00, 1'b0);
        issue("R6 abs,X wrap 64K", 4'd5, 16'h0310, 8'h20, 8'h00, 1'b0);
        issue("R6 abs,Y page carry", 4'd6, 16'h0320, 8'h00, 8'h01, 1'b0);
        issue("R7 indirect ptr carry", 4'd7, 16'h0400, 8'h00, 8'h00, 1'b0);
        issue("R8 idx-ind ptr 00FF", 4'd8, 16'h0500, 8'h01, 8'h00, 1'b0);
        issue("R8 idx-ind zp wrap", 4'd8, 16'h0510, 8'h90, 8'h00, 1'b0);
        issue("R9 relative negative", 4'd9, 16'h0600, 8'h00, 8'h00, 1'b0);
        issue("R9 relative positive", 4'd9, 16'h0610, 8'h00, 8'h00, 1'b0);
        issue("R9 relative wrap", 4'd9, 16'hFFFF, 8'h00, 8'h00, 1'b0);
        issue("R11 start ignored while busy", 4'd4, 16'h0300, 8'h00, 8'h00, 1'b1);

        stall_en = 1'b1;
        issue("R10 stalled indirect", 4'd7, 16'h0400, 8'h00, 8'h00, 1'b0);
        issue("R10 stalled idx-ind", 4'd8, 16'h0500, 8'h01, 8'h00, 1'b0);
        issue("R10 stalled abs,X", 4'd5, 16'h0310, 8'h20, 8'h00, 1'b0);
        issue("R10 stalled zp,Y", 4'd3, 16'h0220, 8'h00, 8'hFB, 1'b1);
        stall_en = 1'b0;

        repeat (4) @(negedge clk);
        check("R11 one done per start", n_done, n_issued);
        check("R11 scoreboard drained", sbq.size(), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule